// File: doc/BRIEF.md
# General-Purpose I/O Controller with Edge Interrupts and Wakeup

This block provides two 16-bit bidirectional ports for a processor subsystem. Software sets the direction of every bit on its own, drives output bits through an output latch, and reads input bits after they have passed a two-flop synchroniser. Reads and writes go through a small register interface with a 3-bit address and a write strobe. Read data is combinational from the address.

Two fixed bits of port 1, bits 14 and 15, can each raise an interrupt on a rising edge. Each has its own enable and a sticky pending flag, and software clears the flag by writing 1 to it. The four lowest bits of port 0 can each be chosen as a wakeup source. While the system sleeps, any chosen source that is an input and is high asserts a level-sensitive wake request. A pin acts as an interrupt or wakeup source only while its direction bit makes it an input.

Register map (address: content): 0 port-0 direction, 1 port-0 data, 2 port-1 direction, 3 port-1 data, 4 interrupt enables (bit 0 for port-1 bit 14, bit 1 for port-1 bit 15), 5 interrupt pending flags (same bit order, write 1 to clear), 6 wakeup enables (bits 3:0 for port-0 bits 3:0), 7 unused. A direction bit of 1 makes that pin an output.

Top module: `gpio_edge_wake`

## Requirements
- R1: After reset, every register reads 0, all direction bits are inputs (output enables 0), the output latches are 0, and irq_o and wake_o are 0.
- R2: Writing address 0 or 2 stores the port's direction register. A direction bit of 1 drives the matching output-enable pin high, and the register reads back as written.
- R3: Reading address 1 or 3 returns, for each bit, the output latch when the direction bit is 1 and the synchronised pin when it is 0. A pin change becomes visible after two rising clock edges.
- R4: Writing address 1 or 3 loads the port's output latch for all 16 bits, whatever the direction. The latch appears on the port's output pins.
- R5: A synchronised 0-to-1 transition on port-1 bit 14 (bit 15) sets pending bit 0 (bit 1) when that interrupt is enabled and the pin is an input. irq_o bit i is pending bit i ANDed with enable bit i.
- R6: A falling edge, or a pin that stays high, does not set a pending flag.
- R7: An edge on an interrupt pin whose direction bit is 1 does not set its pending flag. An edge while the enable is 0 does not set it either.
- R8: A pending flag stays set until software writes 1 to its bit at address 5. Writing 0 leaves it set.
- R9: Clearing an enable bit forces the matching irq_o bit low but leaves the pending flag readable at address 5.
- R10: wake_o equals sleep_i ANDed with the OR, over port-0 bits 0 to 3, of (wakeup enable AND direction bit 0 AND synchronised pin high).
- R11: Address 7 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| p0_in_i | input | 16 | Port 0 pin inputs |
| p0_out_o | output | 16 | Port 0 output latch |
| p0_oe_o | output | 16 | Port 0 output enables |
| p1_in_i | input | 16 | Port 1 pin inputs |
| p1_out_o | output | 16 | Port 1 output latch |
| p1_oe_o | output | 16 | Port 1 output enables |
| sleep_i | input | 1 | System is in sleep |
| irq_o | output | 2 | Interrupt requests (bit 0: port-1 bit 14, bit 1: port-1 bit 15) |
| wake_o | output | 1 | Wake request |

## Verification
The hardest cases to reach are the ones where an edge must not count: a pin that is already high when its interrupt is enabled, a falling edge, and a rising edge on a pin that is an output. The bench reaches each one by placing the pin level, waiting for the synchroniser to settle, and only then changing the enable, the direction or the pin. It then reads the pending register. The wake logic is swept over every combination of sleep state, wakeup-enable pattern and low-nibble pin value, under several direction settings, and each result is compared with a value computed from R10.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int NUM_IRQ  = 2;
    localparam int IRQ_BASE = 14;
    localparam int NUM_WAKE = 4;

    localparam logic [ADDR_W-1:0] A_DIR0    = 3'd0;
    localparam logic [ADDR_W-1:0] A_DAT0    = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIR1    = 3'd2;
    localparam logic [ADDR_W-1:0] A_DAT1    = 3'd3;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IRQ_PND = 3'd5;
    localparam logic [ADDR_W-1:0] A_WAKE_EN = 3'd6;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_DIR   = 2'd1,
        ACC_DATA  = 2'd2
    } port_acc_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] latch;
    } port_state_t;

    // Per-bit read selection: output bits return the latch, input bits the pin.
    function automatic logic [PORT_W-1:0] port_read(
        input logic [PORT_W-1:0] dir,
        input logic [PORT_W-1:0] latch,
        input logic [PORT_W-1:0] pins
    );
        return (dir & latch) | (~dir & pins);
    endfunction

    function automatic port_acc_e port_decode(
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] dir_addr,
        input logic [ADDR_W-1:0] dat_addr
    );
        if (addr == dir_addr) return ACC_DIR;
        if (addr == dat_addr) return ACC_DATA;
        return ACC_NONE;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d_i;
            stable_q <= meta_q;
        end
    end

    assign q_o = stable_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DIR_ADDR = A_DIR0,
    parameter logic [ADDR_W-1:0] DAT_ADDR = A_DAT0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PORT_W-1:0] wdata_i,
    input  logic [PORT_W-1:0] pin_sync_i,
    output port_state_t       state_o,
    output logic [PORT_W-1:0] rd_val_o
);
    port_state_t st_q;
    port_acc_e   acc;

    assign acc = port_decode(addr_i, DIR_ADDR, DAT_ADDR);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else if (we_i) begin
            case (acc)
                ACC_DIR:  st_q.dir   <= wdata_i;
                ACC_DATA: st_q.latch <= wdata_i;
                default:  ;
            endcase
        end
    end

    assign state_o  = st_q;
    assign rd_val_o = port_read(st_q.dir, st_q.latch, pin_sync_i);

    // R2
    dir_write_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(st_q.dir) |-> $past(we_i) && ($past(addr_i) == DIR_ADDR));

    // R4
    latch_write_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(st_q.latch) |-> $past(we_i) && ($past(addr_i) == DAT_ADDR));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] src_sync_i,
    input  logic [N-1:0] src_is_in_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] en_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;
    logic [N-1:0] set_mask;
    logic [N-1:0] clr_mask;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= src_sync_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        en_q <= '0;
        else if (en_we_i) en_q <= wdata_i;
    end

    always_comb begin
        rise     = src_sync_i & ~prev_q;
        set_mask = rise & src_is_in_i & en_q;
        clr_mask = clr_we_i ? wdata_i : '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pend_q <= '0;
        else       pend_q <= (pend_q & ~clr_mask) | set_mask;
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign irq_o  = pend_q & en_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R5
        pend_set_qualified_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(pend_q[i]) |-> $past(en_q[i]) && $past(src_is_in_i[i]));

        // R8
        pend_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(pend_q[i]) |-> $past(clr_we_i) && $past(wdata_i[i]));
    end
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake
    import gpio_pkg::*;
#(
    parameter int N = NUM_WAKE
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_we_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] pin_sync_i,
    input  logic [N-1:0] dir_i,
    input  logic         sleep_i,
    output logic [N-1:0] en_o,
    output logic         wake_o
);
    logic [N-1:0] en_q;
    logic [N-1:0] src_live;

    always_ff @(posedge clk_i) begin
        if (rst_i)        en_q <= '0;
        else if (en_we_i) en_q <= wdata_i;
    end

    assign src_live = en_q & ~dir_i & pin_sync_i;
    assign en_o     = en_q;
    assign wake_o   = sleep_i & (|src_live);

    // R10
    wake_needs_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_o |-> (en_q != '0) && sleep_i);
endmodule

// File: rtl/gpio_edge_wake.sv
module gpio_edge_wake
    import gpio_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [PORT_W-1:0] reg_wdata_i,
    output logic [PORT_W-1:0] reg_rdata_o,
    input  logic [PORT_W-1:0] p0_in_i,
    output logic [PORT_W-1:0] p0_out_o,
    output logic [PORT_W-1:0] p0_oe_o,
    input  logic [PORT_W-1:0] p1_in_i,
    output logic [PORT_W-1:0] p1_out_o,
    output logic [PORT_W-1:0] p1_oe_o,
    input  logic              sleep_i,
    output logic [NUM_IRQ-1:0] irq_o,
    output logic              wake_o
);
    logic [PORT_W-1:0]   p0_sync, p1_sync;
    logic [PORT_W-1:0]   p0_rd, p1_rd;
    port_state_t         p0_st, p1_st;
    logic [NUM_IRQ-1:0]  irq_en, irq_pend;
    logic [NUM_WAKE-1:0] wake_en;
    logic                irq_en_we, irq_clr_we, wake_en_we;

    gpio_sync #(.W(PORT_W)) sync0_i (.clk_i(clk_i), .rst_i(rst_i), .d_i(p0_in_i), .q_o(p0_sync));
    gpio_sync #(.W(PORT_W)) sync1_i (.clk_i(clk_i), .rst_i(rst_i), .d_i(p1_in_i), .q_o(p1_sync));

    gpio_port #(.DIR_ADDR(A_DIR0), .DAT_ADDR(A_DAT0)) port0_i (
        .clk_i(clk_i), .rst_i(rst_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .pin_sync_i(p0_sync), .state_o(p0_st), .rd_val_o(p0_rd)
    );

    gpio_port #(.DIR_ADDR(A_DIR1), .DAT_ADDR(A_DAT1)) port1_i (
        .clk_i(clk_i), .rst_i(rst_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .pin_sync_i(p1_sync), .state_o(p1_st), .rd_val_o(p1_rd)
    );

    assign irq_en_we  = reg_we_i && (reg_addr_i == A_IRQ_EN);
    assign irq_clr_we = reg_we_i && (reg_addr_i == A_IRQ_PND);
    assign wake_en_we = reg_we_i && (reg_addr_i == A_WAKE_EN);

    gpio_edge_irq #(.N(NUM_IRQ)) irq_i (
        .clk_i(clk_i), .rst_i(rst_i),
        .en_we_i(irq_en_we), .clr_we_i(irq_clr_we),
        .wdata_i(reg_wdata_i[NUM_IRQ-1:0]),
        .src_sync_i(p1_sync[IRQ_BASE +: NUM_IRQ]),
        .src_is_in_i(~p1_st.dir[IRQ_BASE +: NUM_IRQ]),
        .en_o(irq_en), .pend_o(irq_pend), .irq_o(irq_o)
    );

    gpio_wake #(.N(NUM_WAKE)) wake_i (
        .clk_i(clk_i), .rst_i(rst_i),
        .en_we_i(wake_en_we), .wdata_i(reg_wdata_i[NUM_WAKE-1:0]),
        .pin_sync_i(p0_sync[NUM_WAKE-1:0]), .dir_i(p0_st.dir[NUM_WAKE-1:0]),
        .sleep_i(sleep_i), .en_o(wake_en), .wake_o(wake_o)
    );

    assign p0_out_o = p0_st.latch;
    assign p0_oe_o  = p0_st.dir;
    assign p1_out_o = p1_st.latch;
    assign p1_oe_o  = p1_st.dir;

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_DIR0:    reg_rdata_o = p0_st.dir;
            A_DAT0:    reg_rdata_o = p0_rd;
            A_DIR1:    reg_rdata_o = p1_st.dir;
            A_DAT1:    reg_rdata_o = p1_rd;
            A_IRQ_EN:  reg_rdata_o[NUM_IRQ-1:0]  = irq_en;
            A_IRQ_PND: reg_rdata_o[NUM_IRQ-1:0]  = irq_pend;
            A_WAKE_EN: reg_rdata_o[NUM_WAKE-1:0] = wake_en;
            default:   reg_rdata_o = '0;
        endcase
    end

    // R9
    irq_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(irq_en[0]) |-> !irq_o[0]);
endmodule

// File: tb/gpio_edge_wake_tb.sv
module gpio_edge_wake_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  addr;
    logic        we;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [15:0] p0_in, p0_out, p0_oe, p1_in, p1_out, p1_oe;
    logic        sleep;
    logic [1:0]  irq;
    logic        wake;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_wake dut_i (
        .clk_i(clk), .rst_i(rst), .reg_addr_i(addr), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .p0_in_i(p0_in), .p0_out_o(p0_out), .p0_oe_o(p0_oe),
        .p1_in_i(p1_in), .p1_out_o(p1_out), .p1_oe_o(p1_oe),
        .sleep_i(sleep), .irq_o(irq), .wake_o(wake)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // pins are changed at a negedge; four more negedges cover synchroniser and edge stage
    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        rst = 1'b1; addr = '0; we = 1'b0; wdata = '0;
        p0_in = '0; p1_in = '0; sleep = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 16'h0);
        end
        check("R1 p0_oe", p0_oe, 16'h0);
        check("R1 p1_oe", p1_oe, 16'h0);
        check("R1 p0_out", p0_out, 16'h0);
        check("R1 p1_out", p1_out, 16'h0);
        check("R1 irq", {14'h0, irq}, 16'h0);
        check("R1 wake", {15'h0, wake}, 16'h0);

        // R2 / R4 walking ones and patterns on both ports
        for (int b = 0; b < 18; b++) begin
            logic [15:0] pat;
            pat = (b < 16) ? (16'h1 << b) : ((b == 16) ? 16'hA5C3 : 16'hFFFF);
            wr(3'd0, pat);  rd(3'd0, v); check("R2 dir0 rb", v, pat); check("R2 p0_oe", p0_oe, pat);
            wr(3'd2, ~pat); rd(3'd2, v); check("R2 dir1 rb", v, ~pat); check("R2 p1_oe", p1_oe, ~pat);
            wr(3'd1, pat ^ 16'h3C3C); check("R4 p0_out", p0_out, pat ^ 16'h3C3C);
            wr(3'd3, ~pat);           check("R4 p1_out", p1_out, ~pat);
        end

        // R3 read mux under mixed direction and pin patterns
        for (int k = 0; k < 6; k++) begin
            logic [15:0] d0, l0, pn;
            d0 = 16'h00FF << (k * 2);
            l0 = 16'h9A6C ^ (16'h1111 * k);
            pn = 16'h5F03 + 16'(k * 16'h0731);
            p0_in = pn; p1_in = ~pn;
            wr(3'd0, d0); wr(3'd1, l0);
            wr(3'd2, ~d0); wr(3'd3, ~l0);
            settle();
            rd(3'd1, v); check("R3 dat0", v, (d0 & l0) | (~d0 & pn));
            rd(3'd3, v); check("R3 dat1", v, (~d0 & ~l0) | (d0 & ~pn));
        end
        // R3 two-edge latency
        wr(3'd0, 16'h0000); p0_in = 16'h0000; settle();
        @(negedge clk); p0_in = 16'h0001;
        @(negedge clk); rd(3'd1, v); check("R3 one edge", v, 16'h0000);
        @(negedge clk); rd(3'd1, v); check("R3 two edges", v, 16'h0001);

        // R11 unused address
        wr(3'd0, 16'h1234); wr(3'd2, 16'h0F0F);
        wr(3'd7, 16'hFFFF);
        rd(3'd7, v); check("R11 read7", v, 16'h0);
        rd(3'd0, v); check("R11 dir0 kept", v, 16'h1234);
        rd(3'd2, v); check("R11 dir1 kept", v, 16'h0F0F);
        rd(3'd4, v); check("R11 en kept", v, 16'h0);
        rd(3'd6, v); check("R11 wake kept", v, 16'h0);

        // interrupts
        for (int i = 0; i < 2; i++) begin
            logic [15:0] pin, m;
            pin = 16'h1 << (14 + i);
            m   = 16'h1 << i;
            wr(3'd2, 16'h0000); p1_in = 16'h0000; wr(3'd4, 16'h0000); wr(3'd5, 16'h3);
            settle();
            // R7 disabled: rise ignored
            p1_in = pin; settle();
            rd(3'd5, v); check("R7 disabled edge", v, 16'h0);
            // R6 steady high after enable
            wr(3'd4, m); settle();
            rd(3'd5, v); check("R6 steady high", v, 16'h0);
            check("R6 irq", {14'h0, irq}, 16'h0);
            // R6 falling edge
            p1_in = 16'h0000; settle();
            rd(3'd5, v); check("R6 falling", v, 16'h0);
            // R5 rising edge
            p1_in = pin; settle();
            rd(3'd5, v); check("R5 pending", v, m);
            check("R5 irq", {14'h0, irq}, m);
            // R8 write 0 keeps, write 1 clears
            wr(3'd5, 16'h0000); rd(3'd5, v); check("R8 write0 keeps", v, m);
            p1_in = 16'h0000; settle();
            rd(3'd5, v); check("R8 sticky after fall", v, m);
            wr(3'd5, m); rd(3'd5, v); check("R8 cleared", v, 16'h0);
            check("R8 irq low", {14'h0, irq}, 16'h0);
            // R9 mask
            p1_in = pin; settle();
            wr(3'd4, 16'h0000);
            check("R9 irq masked", {14'h0, irq}, 16'h0);
            rd(3'd5, v); check("R9 pending kept", v, m);
            wr(3'd5, m); p1_in = 16'h0000;
            // R7 output direction ignores edge
            wr(3'd4, m); wr(3'd2, pin); settle();
            p1_in = pin; settle();
            rd(3'd5, v); check("R7 output edge", v, 16'h0);
            check("R7 irq", {14'h0, irq}, 16'h0);
            p1_in = 16'h0000; wr(3'd2, 16'h0000); wr(3'd4, 16'h0000);
        end

        // R10 wake sweep
        for (int d = 0; d < 3; d++) begin
            logic [3:0] dirn;
            dirn = (d == 0) ? 4'h0 : ((d == 1) ? 4'h5 : 4'hF);
            wr(3'd0, {12'h0, dirn});
            for (int e = 0; e < 16; e++) begin
                wr(3'd6, 16'(e));
                for (int p = 0; p < 16; p++) begin
                    p0_in = {12'hABC, 4'(p)};
                    settle();
                    for (int s = 0; s < 2; s++) begin
                        logic expw;
                        sleep = s[0];
                        #1;
                        expw = s[0] & (|(4'(e) & ~dirn & 4'(p)));
                        check("R10 wake", {15'h0, wake}, {15'h0, expw});
                    end
                end
            end
        end
        sleep = 1'b0;
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule